// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This block gathers eight event sources of a serial-bus peripheral into one interrupt line. Each event, presented as a one-cycle strobe or a level on its input, sets a sticky bit in a status register. An enable register selects which of the sticky bits may raise the interrupt. A single global enable bit then gates the line as a whole. Software clears a status bit by writing a one to that bit.

The unit also holds a keyed reset register. A write of the fixed key value to it produces a one-cycle reset pulse for the rest of the peripheral and returns the unit's own registers to their reset values. A write of any other value to that register does nothing. All accesses are 32-bit writes and reads on a simple strobe-based register port. Read data is registered and appears one cycle after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset, the status, enable and global enable registers read zero, and `irq_o` and `periph_rst_o` are low.
- R2: The register map is: global enable at 0x1C (only bit 31 is stored, and all other bits read zero), status at 0x20 (bits 7:0), enable at 0x28 (bits 7:0), and reset key at 0x40 (reads zero). Any other address reads zero. Read data appears on `reg_rdata_o` in the cycle after `reg_rd_i`.
- R3: A high level on `evt_i[k]` at a clock edge sets status bit k, and the bit stays set until it is cleared. The source bits are:
  - bit 0: arbitration lost
  - bit 1: transmit error or completion
  - bit 2: transmit empty
  - bit 3: receive at level
  - bit 4: bus not busy
  - bit 5: addressed as slave
  - bit 6: not addressed as slave
  - bit 7: transmit half empty
- R4: Writing a one to bit k of the status register clears status bit k.
- R5: Writing a zero to bit k of the status register leaves status bit k unchanged.
- R6: When an event and a clearing write hit the same bit in the same cycle, the event wins and the bit stays set.
- R7: `irq_o` is registered. It is high exactly one cycle after the global enable is set and (status AND enable) is nonzero. It goes low one cycle after the pending set becomes empty.
- R8: When the global enable bit (bit 31 at 0x1C) is zero, `irq_o` stays low whatever the pending set holds.
- R9: A write of 0x0000000A to 0x40 drives `periph_rst_o` high for exactly the next cycle. The same write clears status, enable and global enable, and events arriving in that cycle are discarded.
- R10: A write of any value other than 0x0000000A to 0x40 leaves `periph_rst_o` low and all registers unchanged.
- R11: A status bit whose enable bit is clear does not raise `irq_o`, but it still reads back as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W (8) | Byte address of the register |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Registered read data |
| evt_i | input | NUM_SRC (8) | Event inputs, one per status bit |
| irq_o | output | 1 | Registered interrupt line |
| periph_rst_o | output | 1 | One-cycle reset pulse for the peripheral |

## Verification
The main path is driven through a vector table that pairs different event patterns with different enable masks and global enable settings:
- A single enabled source, gated on and then off, tells the global gate apart from the mask.
- Events confined to bits that are disabled show that masking keeps the status readable while the line stays quiet.
- An all-zero event pattern with every enable set shows the line does not rise on its own.

Directed sequences then cover:
- the cycle-exact latency of `irq_o` on the way up and on the way down;
- the race between an event and a clearing write;
- the key and non-key writes to the reset register.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam logic [7:0] OFS_GLOBAL_EN = 8'h1C;
  localparam logic [7:0] OFS_STATUS    = 8'h20;
  localparam logic [7:0] OFS_ENABLE    = 8'h28;
  localparam logic [7:0] OFS_RST_KEY   = 8'h40;
  localparam logic [31:0] SOFT_RST_KEY = 32'h0000_000A;

  // Meaning of each source position
  typedef enum logic [2:0] {
    SRC_ARB_LOST   = 3'd0,
    SRC_TX_ERR     = 3'd1,
    SRC_TX_EMPTY   = 3'd2,
    SRC_RX_LEVEL   = 3'd3,
    SRC_BUS_IDLE   = 3'd4,
    SRC_SLV_HIT    = 3'd5,
    SRC_SLV_MISS   = 3'd6,
    SRC_TX_HALF    = 3'd7
  } src_idx_e;

  typedef struct packed {
    logic gie;
    logic sts;
    logic ena;
    logic key;
  } reg_sel_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);
  always_comb begin
    sel_o.gie = (addr_i == ADDR_W'(OFS_GLOBAL_EN));
    sel_o.sts = (addr_i == ADDR_W'(OFS_STATUS));
    sel_o.ena = (addr_i == ADDR_W'(OFS_ENABLE));
    sel_o.key = (addr_i == ADDR_W'(OFS_RST_KEY));
  end

  // R2: at most one register selected per address
  always_comb begin
    a_r2_sel_onehot: assert ($onehot0({sel_o.gie, sel_o.sts, sel_o.ena, sel_o.key}));
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wipe_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] status_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
    logic bit_q;
    logic clr_hit;
    assign clr_hit = clr_we_i & clr_mask_i[k];

    always_ff @(posedge clk) begin
      if (rst || wipe_i) bit_q <= 1'b0;
      else if (evt_i[k]) bit_q <= 1'b1;
      else if (clr_hit)  bit_q <= 1'b0;
    end
    assign status_o[k] = bit_q;

    a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
      (evt_i[k] && !wipe_i) |=> status_o[k]);
    a_r4_one_clears: assert property (@(posedge clk) disable iff (rst)
      (clr_hit && !evt_i[k] && !wipe_i) |=> !status_o[k]);
    a_r5_zero_keeps: assert property (@(posedge clk) disable iff (rst)
      (status_o[k] && !clr_hit && !wipe_i) |=> status_o[k]);
    a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
      (clr_hit && evt_i[k] && !wipe_i) |=> status_o[k]);
  end
endmodule

// File: rtl/irq_soft_reset.sv
module irq_soft_reset #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic              pulse_o
);
  assign hit_o = wr_i & sel_i & (wdata_i == DATA_W'(KEY));

  always_ff @(posedge clk) begin
    if (rst) pulse_o <= 1'b0;
    else     pulse_o <= hit_o;
  end

  a_r9_key_pulses: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> pulse_o);
  a_r10_other_quiet: assert property (@(posedge clk) disable iff (rst)
    !hit_o |=> !pulse_o);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               irq_o,
  output logic               periph_rst_o
);
  localparam int GIE_BIT = DATA_W - 1;

  reg_sel_t           sel;
  logic               wipe;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] enable_q;
  logic               gie_q;
  logic               irq_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [NUM_SRC-1:0] pending;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (reg_addr_i),
    .sel_o  (sel)
  );

  irq_soft_reset #(.DATA_W(DATA_W), .KEY(SOFT_RST_KEY)) u_srst (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr_i),
    .sel_i   (sel.key),
    .wdata_i (reg_wdata_i),
    .hit_o   (wipe),
    .pulse_o (periph_rst_o)
  );

  irq_status_bank #(.NUM_SRC(NUM_SRC)) u_sts (
    .clk        (clk),
    .rst        (rst),
    .wipe_i     (wipe),
    .evt_i      (evt_i),
    .clr_we_i   (reg_wr_i & sel.sts),
    .clr_mask_i (reg_wdata_i[NUM_SRC-1:0]),
    .status_o   (status)
  );

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      enable_q <= '0;
      gie_q    <= 1'b0;
    end else if (reg_wr_i) begin
      if (sel.ena) enable_q <= reg_wdata_i[NUM_SRC-1:0];
      if (sel.gie) gie_q    <= reg_wdata_i[GIE_BIT];
    end
  end

  assign pending = status & enable_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gie_q & (|pending);
  end
  assign irq_o = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd_i) begin
      rdata_q <= '0;
      if (sel.gie) rdata_q[GIE_BIT]       <= gie_q;
      if (sel.sts) rdata_q[NUM_SRC-1:0]   <= status;
      if (sel.ena) rdata_q[NUM_SRC-1:0]   <= enable_q;
    end
  end
  assign reg_rdata_o = rdata_q;

  a_r7_empty_drops: assert property (@(posedge clk) disable iff (rst)
    (pending == '0) |=> !irq_o);
  a_r8_gate_off: assert property (@(posedge clk) disable iff (rst)
    !gie_q |=> !irq_o);
  a_r9_wipe_regs: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (status == '0 && enable_q == '0 && !gie_q));
  a_r10_key_other: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && sel.key && !wipe) |=> !periph_rst_o);
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  evt = '0;
  logic        irq, prst;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst(rst), .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq),
    .periph_rst_o(prst)
  );

  // {enable[7:0], gie, events[7:0], expected irq}
  localparam logic [17:0] VEC [6] = '{
    {8'h01, 1'b1, 8'h01, 1'b1},
    {8'h01, 1'b0, 8'h01, 1'b0},
    {8'hF0, 1'b1, 8'h0F, 1'b0},
    {8'h80, 1'b1, 8'h81, 1'b1},
    {8'hFF, 1'b1, 8'h00, 1'b0},
    {8'h00, 1'b1, 8'hFF, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 0);
    chk(prst == 1'b0, "R1 periph_rst", {31'b0, prst}, 0);
    rd_reg(8'h20, v); chk(v == 0, "R1 status", v, 0);
    rd_reg(8'h28, v); chk(v == 0, "R1 enable", v, 0);
    rd_reg(8'h1C, v); chk(v == 0, "R1 gie", v, 0);

    // Vector table: R3 R7 R8 R11
    foreach (VEC[i]) begin
      wr_reg(8'h20, 32'hFF);
      wr_reg(8'h28, {24'b0, VEC[i][17:10]});
      wr_reg(8'h1C, {VEC[i][9], 31'b0});
      pulse(VEC[i][8:1]);
      @(negedge clk);
      chk(irq == VEC[i][0], $sformatf("R7/R8/R11 vec%0d irq", i), {31'b0, irq}, {31'b0, VEC[i][0]});
      rd_reg(8'h20, v);
      chk(v == {24'b0, VEC[i][8:1]}, $sformatf("R3 vec%0d status", i), v, {24'b0, VEC[i][8:1]});
    end

    // R2 map
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    rd_reg(8'h1C, v); chk(v == 32'h8000_0000, "R2 gie bit31 only", v, 32'h8000_0000);
    wr_reg(8'h28, 32'hFFFF_FFFF);
    rd_reg(8'h28, v); chk(v == 32'hFF, "R2 enable width", v, 32'hFF);
    rd_reg(8'h24, v); chk(v == 0, "R2 unmapped", v, 0);
    rd_reg(8'h40, v); chk(v == 0, "R2 key reads zero", v, 0);

    // R4 / R5 write-one-to-clear
    wr_reg(8'h20, 32'hFF);
    pulse(8'h0F);
    wr_reg(8'h20, 32'h05);
    rd_reg(8'h20, v); chk(v == 32'h0A, "R4 ones clear", v, 32'h0A);
    chk(v[1] && v[3], "R5 zeros keep", v, 32'h0A);

    // R6 event wins over clear
    wr_reg(8'h20, 32'hFF);
    @(negedge clk); evt = 8'h01; wr = 1'b1; addr = 8'h20; wdata = 32'h01;
    @(negedge clk); evt = '0; wr = 1'b0;
    rd_reg(8'h20, v); chk(v == 32'h01, "R6 event wins", v, 32'h01);

    // R7 latency
    wr_reg(8'h20, 32'hFF);
    wr_reg(8'h28, 32'h01);
    wr_reg(8'h1C, 32'h8000_0000);
    @(negedge clk);
    @(negedge clk); evt = 8'h01;
    @(negedge clk); evt = '0;
    chk(irq == 1'b0, "R7 rise one cycle late", {31'b0, irq}, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R7 rise", {31'b0, irq}, 1);
    wr_reg(8'h20, 32'h01);
    chk(irq == 1'b1, "R7 fall one cycle late", {31'b0, irq}, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R7 fall", {31'b0, irq}, 0);

    // R10 non-key write
    wr_reg(8'h28, 32'hFF);
    pulse(8'h3C);
    @(negedge clk); wr = 1'b1; addr = 8'h40; wdata = 32'h5;
    @(negedge clk); wr = 1'b0;
    chk(prst == 1'b0, "R10 no pulse", {31'b0, prst}, 0);
    rd_reg(8'h20, v); chk(v == 32'h3C, "R10 status kept", v, 32'h3C);
    rd_reg(8'h28, v); chk(v == 32'hFF, "R10 enable kept", v, 32'hFF);

    // R9 key write
    @(negedge clk); wr = 1'b1; addr = 8'h40; wdata = 32'hA; evt = 8'h40;
    @(negedge clk); wr = 1'b0; evt = '0;
    chk(prst == 1'b1, "R9 pulse high", {31'b0, prst}, 1);
    @(negedge clk);
    chk(prst == 1'b0, "R9 pulse one cycle", {31'b0, prst}, 0);
    chk(irq == 1'b0, "R9 irq low", {31'b0, irq}, 0);
    rd_reg(8'h20, v); chk(v == 0, "R9 status wiped", v, 0);
    rd_reg(8'h28, v); chk(v == 0, "R9 enable wiped", v, 0);
    rd_reg(8'h1C, v); chk(v == 0, "R9 gie wiped", v, 0);

    summary();
  end
endmodule